// File: doc/BRIEF.md
# Write Drain Mode Controller

This block sits beside the read/write arbiter of a DRAM channel controller. It decides, one cycle at a time, whether the channel should keep serving reads, let writes trickle out while single-request read groups are protected, or flush the write queue in one batch. Its inputs are the current write-queue occupancy and a flag that says whether any read group made of one request is waiting. Its outputs are the selected mode and a write-issue enable that the arbiter uses as a gate.

The block uses three occupancy levels, each set by a parameter. A full batch drain starts when the queue reaches the top level. The drain then runs until occupancy falls to the bottom level, so the channel does not switch back and forth near one threshold. Between the middle level and the top level, the controller is in an intermediate mode. In that mode writes may go out only while no single-request read group is pending. Short read groups are therefore not stuck behind a write batch that has not yet been forced.

Top module: `wdc_top`

## Requirements
- R1: Asynchronous active-low reset puts `mode_o` at 0 (read mode) and `wr_en_o` at 0 at once. Mode encoding: 0 = read, 1 = singleton-priority, 2 = drain. The value 3 never appears.
- R2: From read mode or singleton-priority mode, an occupancy at or above `HIGH_WM` at a clock edge selects drain mode from that edge on.
- R3: From read mode, an occupancy at or above `SGL_TH` and below `HIGH_WM` selects singleton-priority mode at the next edge. A lower occupancy keeps read mode.
- R4: In singleton-priority mode, an occupancy below `SGL_TH` returns to read mode at the next edge. An occupancy in [`SGL_TH`, `HIGH_WM`) keeps the mode.
- R5: Drain mode holds while occupancy is above `LOW_WM`. It returns to read mode at the first edge where occupancy is at or below `LOW_WM`, and never goes straight to singleton-priority mode. The levels satisfy `LOW_WM` < `SGL_TH` < `HIGH_WM`.
- R6: `wr_en_o` is 1 in drain mode whatever `sgl_pend_i` is. It is 0 in read mode.
- R7: In singleton-priority mode, `wr_en_o` equals the inverse of `sgl_pend_i` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wq_count_i | input | CNT_W | Write-queue occupancy |
| sgl_pend_i | input | 1 | A read group of one request is pending |
| mode_o | output | 2 | Current mode (0 read, 1 singleton-priority, 2 drain) |
| wr_en_o | output | 1 | Write issue permitted this cycle |

## Verification
The bench walks occupancy across each level, exactly on it and one below it. A design with an off-by-one comparison would enter or leave a mode one entry late. The bench drops occupancy from drain into the singleton band, where a design without hysteresis would leave drain mode early or stop in singleton-priority mode. It also jumps straight from an empty queue to a full one, which must reach drain mode without an intermediate cycle. It toggles the pending flag inside singleton-priority mode without a clock edge; a registered gate would lag one cycle there. Finally it resets in the middle of a drain, which must clear the mode at once, without waiting for the clock.

// File: rtl/wdc_pkg.sv
`timescale 1ns/1ps
package wdc_pkg;
  typedef enum logic [1:0] {
    MODE_READ   = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_DRAIN  = 2'd2
  } wdc_mode_e;
endpackage

// File: rtl/wdc_level_cmp.sv
`timescale 1ns/1ps
module wdc_level_cmp #(
  parameter int CNT_W   = 6,
  parameter int LOW_WM  = 4,
  parameter int SGL_TH  = 16,
  parameter int HIGH_WM = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  output logic             ge_high_o,
  output logic             ge_sgl_o,
  output logic             le_low_o
);
  localparam logic [CNT_W-1:0] HIGH_C = CNT_W'(HIGH_WM);
  localparam logic [CNT_W-1:0] SGL_C  = CNT_W'(SGL_TH);
  localparam logic [CNT_W-1:0] LOW_C  = CNT_W'(LOW_WM);

  assign ge_high_o = (count_i >= HIGH_C);
  assign ge_sgl_o  = (count_i >= SGL_C);
  assign le_low_o  = (count_i <= LOW_C);

  // level ordering: top implies middle, bottom excludes middle
  assert_level_order_hi_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ge_high_o |-> ge_sgl_o);
  assert_level_order_lo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_low_o |-> !ge_sgl_o);
endmodule

// File: rtl/wdc_mode_fsm.sv
`timescale 1ns/1ps
module wdc_mode_fsm
  import wdc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ge_high_i,
  input  logic      ge_sgl_i,
  input  logic      le_low_i,
  output wdc_mode_e mode_o
);
  wdc_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_READ: begin
        if (ge_high_i)     mode_d = MODE_DRAIN;
        else if (ge_sgl_i) mode_d = MODE_SINGLE;
      end
      MODE_SINGLE: begin
        if (ge_high_i)     mode_d = MODE_DRAIN;
        else if (!ge_sgl_i) mode_d = MODE_READ;
      end
      MODE_DRAIN: begin
        if (le_low_i)      mode_d = MODE_READ;
      end
      default:             mode_d = MODE_READ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_READ;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  assert_legal_mode_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != 2'd3);
  assert_drain_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_DRAIN && ge_high_i) |=> mode_q == MODE_DRAIN);
  assert_single_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_READ && ge_sgl_i && !ge_high_i) |=> mode_q == MODE_SINGLE);
  assert_single_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SINGLE && !ge_sgl_i) |=> mode_q == MODE_READ);
  assert_drain_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_DRAIN && !le_low_i) |=> mode_q == MODE_DRAIN);
  assert_drain_no_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == MODE_DRAIN |=> mode_q != MODE_SINGLE);
endmodule

// File: rtl/wdc_issue_gate.sv
`timescale 1ns/1ps
module wdc_issue_gate
  import wdc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  wdc_mode_e mode_i,
  input  logic      sgl_pend_i,
  output logic      wr_en_o
);
  always_comb begin
    unique case (mode_i)
      MODE_DRAIN:  wr_en_o = 1'b1;
      MODE_SINGLE: wr_en_o = !sgl_pend_i;
      default:     wr_en_o = 1'b0;
    endcase
  end

  assert_read_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_READ |-> !wr_en_o);
  assert_drain_issues_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_DRAIN |-> wr_en_o);
  assert_single_yield_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SINGLE && sgl_pend_i) |-> !wr_en_o);
endmodule

// File: rtl/wdc_top.sv
`timescale 1ns/1ps
module wdc_top
  import wdc_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int LOW_WM  = 4,
  parameter int SGL_TH  = 16,
  parameter int HIGH_WM = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] wq_count_i,
  input  logic             sgl_pend_i,
  output logic [1:0]       mode_o,
  output logic             wr_en_o
);
  logic      ge_high, ge_sgl, le_low;
  wdc_mode_e mode;

  wdc_level_cmp #(
    .CNT_W(CNT_W), .LOW_WM(LOW_WM), .SGL_TH(SGL_TH), .HIGH_WM(HIGH_WM)
  ) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .count_i(wq_count_i),
    .ge_high_o(ge_high), .ge_sgl_o(ge_sgl), .le_low_o(le_low)
  );

  wdc_mode_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ge_high_i(ge_high), .ge_sgl_i(ge_sgl), .le_low_i(le_low),
    .mode_o(mode)
  );

  wdc_issue_gate u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode),
    .sgl_pend_i(sgl_pend_i), .wr_en_o(wr_en_o)
  );

  assign mode_o = mode;
endmodule

// File: tb/tb_wdc_top.sv
`timescale 1ns/1ps
module tb_wdc_top;
  localparam int CNT_W = 6;
  localparam int NVEC  = 15;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] cnt = '0;
  logic             sgl = 1'b0;
  logic [1:0]       mode;
  logic             wr_en;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  wdc_top dut (
    .clk_i(clk), .rst_ni(rst_n), .wq_count_i(cnt), .sgl_pend_i(sgl),
    .mode_o(mode), .wr_en_o(wr_en)
  );

  // {count[5:0], pending, expected mode[1:0], expected wr_en}
  localparam logic [9:0] VEC [NVEC] = '{
    {6'd0,  1'b0, 2'd0, 1'b0},  // R3 stay read
    {6'd15, 1'b1, 2'd0, 1'b0},  // R3 one below middle
    {6'd16, 1'b1, 2'd1, 1'b0},  // R3 enter single, R7 pending blocks
    {6'd16, 1'b0, 2'd1, 1'b1},  // R7 no pending
    {6'd20, 1'b1, 2'd1, 1'b0},  // R4 stay single
    {6'd15, 1'b0, 2'd0, 1'b0},  // R4 back to read
    {6'd23, 1'b0, 2'd1, 1'b1},  // R3 one below top
    {6'd24, 1'b1, 2'd2, 1'b1},  // R2 single to drain, R6
    {6'd10, 1'b1, 2'd2, 1'b1},  // R5 hold
    {6'd5,  1'b0, 2'd2, 1'b1},  // R5 one above low
    {6'd4,  1'b0, 2'd0, 1'b0},  // R5 exit at low, R6
    {6'd30, 1'b0, 2'd2, 1'b1},  // R2 read straight to drain
    {6'd16, 1'b1, 2'd2, 1'b1},  // R5 no drop to single
    {6'd0,  1'b0, 2'd0, 1'b0},  // R5 exit
    {6'd63, 1'b1, 2'd2, 1'b1}   // R2 full count
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
      finish_run();
    end
  end

  initial begin
    #1;
    check("R1 reset mode", int'(mode), 0);
    check("R1 reset wr_en", int'(wr_en), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      cnt = VEC[i][9:4];
      sgl = VEC[i][3];
      @(posedge clk);
      #1;
      check($sformatf("vec%0d mode R2-R5", i), int'(mode), int'(VEC[i][2:1]));
      check($sformatf("vec%0d wr_en R6/R7", i), int'(wr_en), int'(VEC[i][0]));
    end

    // R7: flag toggles inside a cycle, gate follows with no edge
    @(negedge clk);
    cnt = 6'd18; sgl = 1'b1;
    @(posedge clk); #1;          // drain exits? count 18 > low: stays drain
    check("R5 hold at 18", int'(mode), 2);
    @(negedge clk); cnt = 6'd2;
    @(posedge clk); #1;
    check("R5 exit to read", int'(mode), 0);
    @(negedge clk); cnt = 6'd17; sgl = 1'b1;
    @(posedge clk); #1;
    check("R3 enter single", int'(mode), 1);
    check("R7 pending", int'(wr_en), 0);
    #1 sgl = 1'b0; #0.5;
    check("R7 same-cycle release", int'(wr_en), 1);
    #0.5 sgl = 1'b1; #0.5;
    check("R7 same-cycle block", int'(wr_en), 0);

    // R1: async reset in the middle of a drain
    @(negedge clk); cnt = 6'd40;
    @(posedge clk); #1;
    check("R2 drain before reset", int'(mode), 2);
    #1 rst_n = 1'b0; #0.5;
    check("R1 async reset mode", int'(mode), 0);
    check("R1 async reset wr_en", int'(wr_en), 0);
    @(negedge clk); cnt = 6'd0; rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 read after reset", int'(mode), 0);

    finish_run();
  end
endmodule